// File: doc/BRIEF.md
# First Hit Pulse Width Encoder

This block watches a set of synchronized hit lines that are grouped into track segments by a programmable segment table. For every segment it takes the OR of that segment's hits and detects the segment's first hit, which is the rising edge of that OR. The edge opens a per-segment window of `WIN_TICKS` clock ticks. Inside that window further activity on the segment does not count as a new first hit.

Across all segments the earliest first hit wins. When several segments have their first hit on the same tick, the lowest index wins. The winning event is held back by `DELAY_TICKS` ticks and then drives one pulse on a single output line. The rising edge of the pulse carries the timing phase of the hit. The width of the pulse carries the identity of the winning segment: segment n (numbered 1 to `NUM_SEG`) produces a pulse n+1 ticks wide.

A parallel index output repeats n while the pulse is high, so the pulse can be checked against it. After a pulse has been armed, no new winner is accepted until every segment window has closed.

Top module: `first_hit_width_enc`

## Requirements
- R1: Segment s (0-based, reported as index n = s+1) sees a first hit when the OR of `hit_i & seg_map_i[s*NUM_HITS +: NUM_HITS]` rises. Any mapped hit can cause it. A hit line that is not mapped to any segment never produces a pulse.
- R2: The output rises exactly `DELAY_TICKS` (default 24) rising clock edges after the edge at which the winning hit is first sampled high.
- R3: The pulse for segment index n stays high for exactly n+1 consecutive ticks. With the default 40 segments the widths run from 2 to 41.
- R4: When several segments have their first hit on the same tick, the segment with the lowest index wins. This holds whether they share a hit line or use separate lines.
- R5: A segment whose first hit is sampled earlier wins over one whose first hit comes later, even when the later one has a lower index.
- R6: Once a first hit is accepted, the block accepts no further first hit until every segment window has closed. A window opens on the edge where a first hit is sampled (edge 0) and still blocks on edges 1 to `WIN_TICKS` (default 112). A first hit sampled on edge `WIN_TICKS`+1 with all windows closed is accepted.
- R7: `seg_idx_o` equals the index n of the current pulse while `pulse_o` is high, and is 0 while `pulse_o` is low.
- R8: While `rst` is high, `pulse_o` and `seg_idx_o` are 0 from the first clock edge on. Reset also aborts a pulse in progress and clears all windows and the lockout, so a new first hit right after reset is accepted.
- R9: A hit held high continuously produces only one first hit. A new first hit needs a fresh rising edge of the segment OR, even after the window has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | NUM_HITS | Synchronized hit lines |
| seg_map_i | input | NUM_SEG*NUM_HITS | Segment table; bit s*NUM_HITS+h places hit h in segment s |
| pulse_o | output | 1 | Encoded pulse: rising edge gives the phase, width n+1 gives the index |
| seg_idx_o | output | 6 | Index n of the segment being sent, 0 when idle |

## Verification
A wrong window counter or lock state shows up as a missing or extra pulse. A second hit placed one tick before or one tick after the end of the window exposes it within about 140 ticks. A corrupted delay stage or priority choice moves the rising edge or changes the width, and appears at the ports `DELAY_TICKS` plus at most 41 ticks after the stimulus. A stuck index or width counter also gives a mismatch between the pulse width and the parallel index while the pulse is still high. Sweeping every segment on its own covers every width.

// File: rtl/fhpw_pkg.sv
package fhpw_pkg;

    // Index field width; supports up to 63 segments.
    localparam int unsigned EV_IDX_W = 6;

    typedef logic [EV_IDX_W-1:0] ev_idx_t;

    // One accepted first-hit event travelling to the pulse generator.
    typedef struct packed {
        logic    valid;
        ev_idx_t idx;
    } first_ev_t;

    localparam first_ev_t EV_NONE = '{valid: 1'b0, idx: '0};

    typedef enum logic {
        ARB_ARMED  = 1'b0,
        ARB_LOCKED = 1'b1
    } arb_state_t;

    function automatic int unsigned win_cnt_w(input int unsigned ticks);
        return $clog2(ticks + 1);
    endfunction

endpackage

// File: rtl/fhpw_seg_window.sv
module fhpw_seg_window
    import fhpw_pkg::*;
#(
    parameter int unsigned NUM_HITS  = 28,
    parameter int unsigned WIN_TICKS = 112
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_HITS-1:0] hit_i,
    input  logic [NUM_HITS-1:0] map_i,
    output logic                first_o,
    output logic                active_o
);

    localparam int unsigned CW = win_cnt_w(WIN_TICKS);

    logic          seg_or;
    logic          seg_or_q;
    logic [CW-1:0] cnt_q;

    assign seg_or   = |(hit_i & map_i);
    assign active_o = (cnt_q != '0);
    // A first hit is a fresh rise of the segment OR outside an open window.
    assign first_o  = seg_or & ~seg_or_q & ~active_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_or_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            seg_or_q <= seg_or;
            if (first_o) begin
                cnt_q <= CW'(WIN_TICKS);
            end else if (active_o) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R6: an accepted edge opens the window on the following cycle
    p_window_opens_r6: assert property (@(posedge clk) disable iff (rst)
        first_o |=> (active_o && cnt_q == CW'(WIN_TICKS)));

    // R9: a level that stays high never yields a second first hit
    p_level_no_refire_r9: assert property (@(posedge clk) disable iff (rst)
        (seg_or && $past(seg_or)) |-> !first_o);

endmodule

// File: rtl/fhpw_arbiter.sv
module fhpw_arbiter
    import fhpw_pkg::*;
#(
    parameter int unsigned NUM_SEG = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SEG-1:0] first_i,
    input  logic [NUM_SEG-1:0] active_i,
    output first_ev_t          ev_o
);

    arb_state_t   state_q;
    arb_state_t   state_d;
    logic         all_idle;
    logic         any_first;
    logic         accept;
    ev_idx_t      win_idx;
    logic [NUM_SEG-1:0] onehot_sel;
    logic [NUM_SEG-1:0] low_mask;

    assign all_idle  = ~|active_i;
    assign any_first = |first_i;

    // Fixed priority: scanning downward leaves the lowest set index.
    always_comb begin
        win_idx = '0;
        for (int s = NUM_SEG - 1; s >= 0; s--) begin
            if (first_i[s]) begin
                win_idx = ev_idx_t'(s + 1);
            end
        end
    end

    assign accept = any_first && ((state_q == ARB_ARMED) || all_idle);

    always_comb begin
        ev_o.valid = accept;
        ev_o.idx   = accept ? win_idx : '0;
    end

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = ARB_LOCKED;
        end else if (all_idle) begin
            state_d = ARB_ARMED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    assign onehot_sel = NUM_SEG'(1) << (ev_o.idx - 1'b1);
    assign low_mask   = onehot_sel - NUM_SEG'(1);

    // R4: the granted segment saw a first hit and none below it did
    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (rst)
        ev_o.valid |-> (((first_i & onehot_sel) != '0) && ((first_i & low_mask) == '0)));

    // R6: two accepted events never come back to back
    p_lockout_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
        ev_o.valid |=> !ev_o.valid);

    // R1: an accepted event always carries an index in range
    p_index_range_r1: assert property (@(posedge clk) disable iff (rst)
        ev_o.valid |-> (ev_o.idx >= 1 && ev_o.idx <= ev_idx_t'(NUM_SEG)));

endmodule

// File: rtl/fhpw_delay_line.sv
module fhpw_delay_line
    import fhpw_pkg::*;
#(
    parameter int unsigned DEPTH = 24
) (
    input  logic      clk,
    input  logic      rst,
    input  first_ev_t ev_i,
    output first_ev_t ev_o
);

    first_ev_t stg_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                stg_q[i] <= EV_NONE;
            end
        end else begin
            stg_q[0] <= ev_i;
            for (int i = 1; i < int'(DEPTH); i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign ev_o = stg_q[DEPTH-1];

    // R2: the first stage always follows its input by one tick
    p_stage_follows_r2: assert property (@(posedge clk) disable iff (rst)
        ev_i.valid |=> (stg_q[0].valid && stg_q[0].idx == $past(ev_i.idx)));

endmodule

// File: rtl/fhpw_pulse_gen.sv
module fhpw_pulse_gen
    import fhpw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  first_ev_t ev_i,
    output logic      pulse_o,
    output ev_idx_t   idx_o
);

    logic    pulse_q;
    ev_idx_t idx_q;
    ev_idx_t rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            idx_q   <= '0;
            rem_q   <= '0;
        end else if (ev_i.valid) begin
            pulse_q <= 1'b1;
            idx_q   <= ev_i.idx;
            rem_q   <= ev_i.idx;
        end else if (pulse_q) begin
            if (rem_q == '0) begin
                pulse_q <= 1'b0;
                idx_q   <= '0;
            end else begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign pulse_o = pulse_q;
    assign idx_o   = idx_q;

    // R3: the lockout guarantees a new event never lands on a live pulse
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        ev_i.valid |-> !pulse_q);

    // R3: the pulse only ends once its width count has run out
    p_width_done_r3: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && !ev_i.valid && rem_q != '0) |=> pulse_q);

    // R7: the index is steady through a pulse and zero when idle
    p_idx_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && $past(pulse_q)) |-> $stable(idx_q));

    p_idx_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !pulse_q |-> (idx_q == '0));

endmodule

// File: rtl/first_hit_width_enc.sv
module first_hit_width_enc
    import fhpw_pkg::*;
#(
    parameter int unsigned NUM_SEG     = 40,
    parameter int unsigned NUM_HITS    = 28,
    parameter int unsigned WIN_TICKS   = 112,
    parameter int unsigned DELAY_TICKS = 24
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_HITS-1:0]          hit_i,
    input  logic [NUM_SEG*NUM_HITS-1:0]  seg_map_i,
    output logic                         pulse_o,
    output logic [EV_IDX_W-1:0]          seg_idx_o
);

    localparam int unsigned IDX_W = EV_IDX_W;

    logic [NUM_SEG-1:0] seg_first;
    logic [NUM_SEG-1:0] seg_active;
    first_ev_t          ev_acc;
    first_ev_t          ev_dly;
    ev_idx_t            idx_w;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        fhpw_seg_window #(
            .NUM_HITS  (NUM_HITS),
            .WIN_TICKS (WIN_TICKS)
        ) u_win (
            .clk      (clk),
            .rst      (rst),
            .hit_i    (hit_i),
            .map_i    (seg_map_i[s*NUM_HITS +: NUM_HITS]),
            .first_o  (seg_first[s]),
            .active_o (seg_active[s])
        );
    end

    fhpw_arbiter #(
        .NUM_SEG (NUM_SEG)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .first_i  (seg_first),
        .active_i (seg_active),
        .ev_o     (ev_acc)
    );

    fhpw_delay_line #(
        .DEPTH (DELAY_TICKS)
    ) u_dly (
        .clk  (clk),
        .rst  (rst),
        .ev_i (ev_acc),
        .ev_o (ev_dly)
    );

    fhpw_pulse_gen u_pg (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev_dly),
        .pulse_o (pulse_o),
        .idx_o   (idx_w)
    );

    assign seg_idx_o = idx_w[IDX_W-1:0];

    // R3: every pulse starts with a legal segment index on the side output
    p_rise_index_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> (seg_idx_o >= 1 && seg_idx_o <= IDX_W'(NUM_SEG)));

    // R8: outputs are cleared on the edge after reset is seen
    p_reset_clears_r8: assert property (@(posedge clk)
        $past(rst) |-> (!pulse_o && seg_idx_o == '0));

endmodule

// File: tb/tb_first_hit_width_enc.sv
module tb_first_hit_width_enc;

    localparam int NS  = 40;
    localparam int NH  = 28;
    localparam int WIN = 112;
    localparam int DLY = 24;
    localparam int IW  = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic [NH-1:0]    hit;
    logic [NS*NH-1:0] seg_map;
    logic             pulse;
    logic [IW-1:0]    idx;

    always #2 clk = ~clk;   // 250 MHz

    first_hit_width_enc #(
        .NUM_SEG (NS), .NUM_HITS (NH), .WIN_TICKS (WIN), .DELAY_TICKS (DLY)
    ) dut (
        .clk (clk), .rst (rst), .hit_i (hit), .seg_map_i (seg_map),
        .pulse_o (pulse), .seg_idx_o (idx)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // measurement results of one run
    int m_rises, m_k1, m_w1, m_i1, m_k2, m_w2, m_i2, m_ierr;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NH-1:0] hb(input int h);
        return NH'(1) << h;
    endfunction

    task automatic map_add(input int s, input int h);
        seg_map[s*NH + h] = 1'b1;
    endtask

    // Drives ma now (tick 0) and mb at tick kb, samples every negedge for len ticks.
    task automatic run(input logic [NH-1:0] ma, input logic [NH-1:0] mb,
                       input int kb, input int len);
        logic prev;
        prev = 1'b0;
        m_rises = 0; m_k1 = -1; m_w1 = 0; m_i1 = -1;
        m_k2 = -1; m_w2 = 0; m_i2 = -1; m_ierr = 0;
        hit = ma;
        if (kb == 0) hit = hit | mb;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (pulse && !prev) begin
                m_rises++;
                if (m_rises == 1) begin m_k1 = k; m_i1 = int'(idx); end
                else if (m_rises == 2) begin m_k2 = k; m_i2 = int'(idx); end
            end
            if (pulse) begin
                if (m_rises == 1) m_w1++; else m_w2++;
                if (int'(idx) != ((m_rises == 1) ? m_i1 : m_i2)) m_ierr++;
            end else if (idx != '0) begin
                m_ierr++;
            end
            prev = pulse;
            if (k == kb) hit = hit | mb;
        end
        hit = '0;
        repeat (160) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; hit = '0; seg_map = '0;
        repeat (3) @(negedge clk);
        chk("R8", "pulse in reset", int'(pulse), 0);
        chk("R8", "index in reset", int'(idx), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 R3 R7: every segment alone, width and phase computed from its index
        for (int s = 0; s < NS; s++) begin
            seg_map = '0;
            map_add(s, s % NH);
            run(hb(s % NH), '0, 0, 260);
            chk("R3", "single seg rises", m_rises, 1);
            chk("R2", "rise tick", m_k1, DLY + 1);
            chk("R3", "width", m_w1, s + 2);
            chk("R7", "index", m_i1, s + 1);
            chk("R7", "index consistency", m_ierr, 0);
        end

        // R1: unmapped line ignored, any mapped line of the OR fires
        seg_map = '0; map_add(7, 5);
        run(hb(6), '0, 0, 260);
        chk("R1", "unmapped hit rises", m_rises, 0);
        chk("R1", "unmapped hit index", m_ierr, 0);
        map_add(7, 6);
        run(hb(6), '0, 0, 260);
        chk("R1", "second OR line rises", m_rises, 1);
        chk("R1", "second OR line index", m_i1, 8);

        // R4: tie on a shared line and on separate lines
        seg_map = '0; map_add(5, 0); map_add(17, 0);
        run(hb(0), '0, 0, 260);
        chk("R4", "shared tie index", m_i1, 6);
        chk("R4", "shared tie width", m_w1, 7);
        seg_map = '0; map_add(9, 3); map_add(4, 4);
        run(hb(3), hb(4), 0, 260);
        chk("R4", "split tie index", m_i1, 5);
        chk("R4", "split tie rises", m_rises, 1);

        // R5: earlier high index beats later low index
        seg_map = '0; map_add(30, 1); map_add(2, 2);
        run(hb(1), hb(2), 3, 260);
        chk("R5", "earliest index", m_i1, 31);
        chk("R5", "earliest width", m_w1, 32);
        chk("R5", "earliest rises", m_rises, 1);

        // R6: lockout inside the window and exactly at its end
        seg_map = '0; map_add(10, 0); map_add(20, 1);
        run(hb(0), hb(1), 60, 300);
        chk("R6", "hit in window rises", m_rises, 1);
        chk("R6", "hit in window index", m_i1, 11);
        run(hb(0), hb(1), WIN, 300);
        chk("R6", "last blocked tick rises", m_rises, 1);
        run(hb(0), hb(1), WIN + 1, 300);
        chk("R6", "first free tick rises", m_rises, 2);
        chk("R6", "second rise tick", m_k2, WIN + 1 + DLY + 1);
        chk("R6", "second index", m_i2, 21);
        chk("R6", "second width", m_w2, 22);

        // R9: held level fires once even past window expiry
        seg_map = '0; map_add(3, 2);
        run(hb(2), '0, 0, 400);
        chk("R9", "held level rises", m_rises, 1);
        chk("R9", "held level index", m_i1, 4);

        // R8: reset aborts a live pulse and clears the lockout
        seg_map = '0; map_add(38, 0); map_add(39, 1);
        hit = hb(1);
        repeat (DLY + 10) @(negedge clk);
        chk("R8", "pulse live before reset", int'(pulse), 1);
        rst = 1'b1; hit = '0;
        @(negedge clk);
        chk("R8", "pulse after reset", int'(pulse), 0);
        chk("R8", "index after reset", int'(idx), 0);
        rst = 1'b0;
        run(hb(0), '0, 0, 260);
        chk("R8", "accept right after reset", m_rises, 1);
        chk("R8", "width right after reset", m_w1, 40);

        summary();
        $finish;
    end

endmodule